// File: doc/BRIEF.md
# SMBus Block Transfer Byte Buffer

This block holds the payload of one SMBus block transfer so that the transfer can run from start to end without software handling each byte. It has 32 entries. Software switches it on through a bit in an auxiliary control register. For a block write, software places the byte count in the count register and then pushes each payload byte through a block-data register. The transaction engine then pops the bytes in order. For a block read, the engine first reports the count it received and then pushes each received byte. Software then pops the bytes through the same block-data register.

Software and the engine each have their own byte index. Any software read of the host control register rewinds the software index to entry 0. An engine start pulse rewinds the engine index. The buffer is used only for SMBus block transfers. When the current transfer is a raw I2C block transfer, buffered mode is reported as off, and the engine must fall back to handshaking one byte at a time.

Top module: `smb_block_buffer`

## Requirements
- R1: After reset the auxiliary, host control and count registers read 0, every buffer entry reads 0, `buf_mode`, `crc_en` and `dev_err` are 0, and both indices are at entry 0.
- R2: The auxiliary register is at address 3. Bit 1 is the buffer enable and bit 0 is the CRC enable. Both bits read back exactly as written, bits 7..2 read 0, and `crc_en` follows bit 0.
- R3: `buf_mode` is 1 only when the auxiliary buffer enable bit is 1 and `xfer_i2c_raw` is 0. While `buf_mode` is 0, engine pushes and pops neither change the buffer nor move the engine index.
- R4: A software write to block data (address 2) stores the byte at the software index and advances the index. A software read of block data returns the byte at the index and advances the index.
- R5: A software read of the host control register (address 0) resets the software index to 0. A write to that register does not move the index. The register reads back the last value written.
- R6: The index stops after 32 accesses. Further software or engine writes are then ignored, and further reads return entry 31.
- R7: After `eng_start`, engine pops return the stored bytes in order from entry 0, and `eng_pop_data` shows the byte at the engine index.
- R8: After `eng_start`, engine pushes store the received bytes from entry 0 onward, and software can read them back.
- R9: A count reported with `eng_cnt_vld` is written into the count register (address 1). A valid count is 1 to 32.
- R10: A reported count of 0 or above 32 sets `dev_err`. Engine pushes are then ignored until the next `eng_start`, which clears `dev_err`.
- R11: Software can write the count register and read it back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Software register write strobe |
| reg_rd | input | 1 | Software register read strobe; side effects take place at the clock edge |
| reg_addr | input | 2 | Register select: 0 host control, 1 count, 2 block data, 3 auxiliary |
| reg_wdata | input | 8 | Software write data |
| reg_rdata | output | 8 | Read data, valid in the cycle of `reg_rd`; 0 otherwise |
| xfer_i2c_raw | input | 1 | The current transfer is a raw I2C block transfer |
| buf_mode | output | 1 | The buffer serves the current transfer |
| crc_en | output | 1 | CRC enable bit of the auxiliary register |
| eng_start | input | 1 | The engine starts a transfer; rewinds the engine index and clears `dev_err` |
| eng_cnt_vld | input | 1 | The engine reports a received byte count |
| eng_cnt | input | 8 | Received byte count |
| eng_push | input | 1 | The engine stores a received byte |
| eng_push_data | input | 8 | Received byte |
| eng_pop | input | 1 | The engine consumes a byte for transmission |
| eng_pop_data | output | 8 | Byte at the engine index |
| dev_err | output | 1 | An invalid received count was reported |

## Verification
The hardest states to reach from the ports are the ones past the end of the buffer. The ports make overrun easy to cause but give no direct view of the index. The stimulus writes random lengths of up to 40 bytes through each path, rewinds, and reads back one position past the overrun. A read that returns entry 31 and not a later write shows that the excess bytes were dropped. Invalid counts are mixed into the random read transfers, so the bench sees pushes blocked after `dev_err` and then a buffer unchanged by those pushes.

// File: rtl/smb_bbuf_pkg.sv
package smb_bbuf_pkg;
    localparam int ADDR_W = 2;
    localparam logic [ADDR_W-1:0] A_HCTL  = 2'd0;
    localparam logic [ADDR_W-1:0] A_COUNT = 2'd1;
    localparam logic [ADDR_W-1:0] A_BDATA = 2'd2;
    localparam logic [ADDR_W-1:0] A_AUX   = 2'd3;
    localparam int AUX_CRC_BIT = 0;
    localparam int AUX_BUF_BIT = 1;
    localparam int AUX_W       = 2;
    localparam int P_SW  = 0;
    localparam int P_ENG = 1;
    localparam int N_PTR = 2;
endpackage

// File: rtl/smb_bbuf_ptr.sv
module smb_bbuf_ptr #(
    parameter  int DEPTH = 32,
    localparam int IW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          adv,
    output logic [IW-1:0] idx,
    output logic          past_end
);
    localparam logic [IW-1:0] LIMIT = IW'(DEPTH);

    logic [IW-1:0] idx_d, idx_q;

    always_comb begin
        idx_d = idx_q;
        if (clr)
            idx_d = '0;
        else if (adv && idx_q != LIMIT)
            idx_d = idx_q + IW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) idx_q <= '0;
        else        idx_q <= idx_d;
    end

    assign idx      = idx_q;
    assign past_end = (idx_q == LIMIT);

    // R6: the index never runs beyond one past the last entry
    a_r6_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q <= LIMIT);

    // R5 / R7: a rewind request always lands on entry 0
    a_r5_clr_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> idx_q == '0);

    // R6: once at the limit, advancing leaves the index there
    a_r6_sat_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (past_end && !clr) |=> past_end);
endmodule

// File: rtl/smb_bbuf_mem.sv
module smb_bbuf_mem #(
    parameter  int DEPTH = 32,
    parameter  int DW    = 8,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr_a,
    input  logic [AW-1:0] raddr_b,
    output logic [DW-1:0] rdata_a,
    output logic [DW-1:0] rdata_b
);
    logic [DW-1:0] mem_d [DEPTH];
    logic [DW-1:0] mem_q [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (we)
            mem_d[waddr] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)
                mem_q[i] <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rdata_a = mem_q[raddr_a];
    assign rdata_b = mem_q[raddr_b];

    // R4 / R8: an accepted write is visible at its entry on the next cycle
    a_r4_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> mem_q[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/smb_bbuf_cnt.sv
module smb_bbuf_cnt #(
    parameter int DEPTH = 32,
    parameter int DW    = 8
) (
    input  logic [DW-1:0] cnt,
    output logic          ok
);
    localparam logic [DW-1:0] MAXC = DW'(DEPTH);

    always_comb begin
        ok = (cnt != '0) && (cnt <= MAXC);
    end
endmodule

// File: rtl/smb_block_buffer.sv
module smb_block_buffer
    import smb_bbuf_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int DW    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    input  logic              xfer_i2c_raw,
    output logic              buf_mode,
    output logic              crc_en,
    input  logic              eng_start,
    input  logic              eng_cnt_vld,
    input  logic [DW-1:0]     eng_cnt,
    input  logic              eng_push,
    input  logic [DW-1:0]     eng_push_data,
    input  logic              eng_pop,
    output logic [DW-1:0]     eng_pop_data,
    output logic              dev_err
);
    localparam int IW = $clog2(DEPTH + 1);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    typedef struct packed {
        logic [DW-1:0]    hctl;
        logic [DW-1:0]    cnt;
        logic [AUX_W-1:0] aux;
        logic             err;
    } regs_t;

    regs_t regs_d, regs_q;

    logic          p_clr [N_PTR];
    logic          p_adv [N_PTR];
    logic [IW-1:0] p_idx [N_PTR];
    logic          p_end [N_PTR];

    logic          sw_bd_wr, sw_bd_rd, hctl_rd;
    logic          eng_wr, sw_wr, mem_we, cnt_ok;
    logic [AW-1:0] sw_addr, eng_addr, mem_waddr;
    logic [DW-1:0] mem_wdata, sw_rbyte;

    assign sw_bd_wr = reg_wr && (reg_addr == A_BDATA);
    assign sw_bd_rd = reg_rd && (reg_addr == A_BDATA);
    assign hctl_rd  = reg_rd && (reg_addr == A_HCTL);
    assign buf_mode = regs_q.aux[AUX_BUF_BIT] && !xfer_i2c_raw;
    assign crc_en   = regs_q.aux[AUX_CRC_BIT];
    assign dev_err  = regs_q.err;

    // pointer controls
    always_comb begin
        p_clr[P_SW]  = hctl_rd;
        p_adv[P_SW]  = sw_bd_wr || sw_bd_rd;
        p_clr[P_ENG] = eng_start;
        p_adv[P_ENG] = buf_mode && !eng_start &&
                       (eng_pop || (eng_push && !regs_q.err));
    end

    genvar g;
    generate
        for (g = 0; g < N_PTR; g++) begin : g_ptr
            smb_bbuf_ptr #(.DEPTH(DEPTH)) u_ptr (
                .clk      (clk),
                .rst_n    (rst_n),
                .clr      (p_clr[g]),
                .adv      (p_adv[g]),
                .idx      (p_idx[g]),
                .past_end (p_end[g])
            );
        end
    endgenerate

    // a saturated index addresses the final entry
    assign sw_addr  = p_end[P_SW]  ? LAST : p_idx[P_SW][AW-1:0];
    assign eng_addr = p_end[P_ENG] ? LAST : p_idx[P_ENG][AW-1:0];

    // write port arbitration: the engine has priority
    always_comb begin
        eng_wr    = buf_mode && eng_push && !regs_q.err && !eng_start && !p_end[P_ENG];
        sw_wr     = sw_bd_wr && !p_end[P_SW];
        mem_we    = eng_wr || sw_wr;
        mem_waddr = eng_wr ? eng_addr : sw_addr;
        mem_wdata = eng_wr ? eng_push_data : reg_wdata;
    end

    smb_bbuf_mem #(.DEPTH(DEPTH), .DW(DW)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (mem_we),
        .waddr   (mem_waddr),
        .wdata   (mem_wdata),
        .raddr_a (sw_addr),
        .raddr_b (eng_addr),
        .rdata_a (sw_rbyte),
        .rdata_b (eng_pop_data)
    );

    smb_bbuf_cnt #(.DEPTH(DEPTH), .DW(DW)) u_cnt (
        .cnt (eng_cnt),
        .ok  (cnt_ok)
    );

    // register file next state
    always_comb begin
        regs_d = regs_q;
        if (reg_wr) begin
            case (reg_addr)
                A_HCTL:  regs_d.hctl = reg_wdata;
                A_COUNT: regs_d.cnt  = reg_wdata;
                A_AUX:   regs_d.aux  = reg_wdata[AUX_W-1:0];
                default: ;
            endcase
        end
        if (eng_cnt_vld)
            regs_d.cnt = eng_cnt;
        if (eng_start)
            regs_d.err = 1'b0;
        if (eng_cnt_vld && !cnt_ok)
            regs_d.err = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    // read data multiplexer
    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            case (reg_addr)
                A_HCTL:  reg_rdata = regs_q.hctl;
                A_COUNT: reg_rdata = regs_q.cnt;
                A_BDATA: reg_rdata = sw_rbyte;
                A_AUX:   reg_rdata = {{(DW-AUX_W){1'b0}}, regs_q.aux};
                default: reg_rdata = '0;
            endcase
        end
    end

    // R10: an out-of-range count raises the error flag
    a_r10_bad_count: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_cnt_vld && (eng_cnt == '0 || eng_cnt > DW'(DEPTH))) |=> dev_err);

    // R10: a start without a count report clears the error flag
    a_r10_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_start && !eng_cnt_vld) |=> !dev_err);

    // R9: a reported count is captured in the count register
    a_r9_count_capture: assert property (@(posedge clk) disable iff (!rst_n)
        eng_cnt_vld |=> regs_q.cnt == $past(eng_cnt));

    // R2: the CRC bit moves only on a write to the auxiliary register
    a_r2_crc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == A_AUX) |=> $stable(crc_en));
endmodule

// File: tb/smb_block_buffer_test.sv
module smb_block_buffer_test;
    localparam logic [1:0] HCTL = 2'd0, CNT = 2'd1, BDAT = 2'd2, AUX = 2'd3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       xfer_i2c_raw = 1'b0;
    logic       buf_mode, crc_en;
    logic       eng_start = 1'b0, eng_cnt_vld = 1'b0, eng_push = 1'b0, eng_pop = 1'b0;
    logic [7:0] eng_cnt = '0, eng_push_data = '0;
    logic [7:0] eng_pop_data;
    logic       dev_err;

    int nchk = 0, nfail = 0;
    logic [7:0] m [32];
    int sidx = 0, eidx = 0;
    logic model_err = 1'b0;
    logic done = 1'b0;

    always #5 clk = ~clk;

    smb_block_buffer uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .xfer_i2c_raw(xfer_i2c_raw), .buf_mode(buf_mode), .crc_en(crc_en),
        .eng_start(eng_start), .eng_cnt_vld(eng_cnt_vld), .eng_cnt(eng_cnt),
        .eng_push(eng_push), .eng_push_data(eng_push_data), .eng_pop(eng_pop),
        .eng_pop_data(eng_pop_data), .dev_err(dev_err)
    );

    function automatic logic [7:0] exp_at(int k);
        return (k >= 32) ? m[31] : m[k];
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        reg_rd = 1'b1; reg_addr = a;
        #1 v = reg_rdata;
        @(negedge clk); reg_rd = 1'b0;
        if (a == HCTL) sidx = 0;
        if (a == BDAT && sidx < 32) sidx++;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
        if (a == BDAT) begin
            if (sidx < 32) begin m[sidx] = d; sidx++; end
        end
    endtask

    task automatic estart();
        eng_start = 1'b1;
        @(negedge clk); eng_start = 1'b0;
        eidx = 0; model_err = 1'b0;
    endtask

    task automatic ecnt(input logic [7:0] c);
        eng_cnt_vld = 1'b1; eng_cnt = c;
        @(negedge clk); eng_cnt_vld = 1'b0;
        if (c == 0 || c > 32) model_err = 1'b1;
    endtask

    task automatic epush(input logic [7:0] d, input logic active);
        eng_push = 1'b1; eng_push_data = d;
        @(negedge clk); eng_push = 1'b0;
        if (active && !model_err && eidx < 32) begin m[eidx] = d; eidx++; end
    endtask

    task automatic epop(output logic [7:0] v, input logic active);
        eng_pop = 1'b1;
        #1 v = eng_pop_data;
        @(negedge clk); eng_pop = 1'b0;
        if (active && eidx < 32) eidx++;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        logic [7:0] v;
        int r;
        for (int i = 0; i < 32; i++) m[i] = 8'h00;
        r = $urandom(32'h5EED_0042);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 dev_err", dev_err, 0);
        chk("R1 buf_mode", buf_mode, 0);
        chk("R1 crc_en", crc_en, 0);
        rd(AUX, v);  chk("R1 aux", v, 8'h00);
        rd(CNT, v);  chk("R1 count", v, 8'h00);
        rd(HCTL, v); chk("R1 hctl", v, 8'h00);
        rd(BDAT, v); chk("R1 entry0", v, 8'h00);

        // R2 auxiliary readback
        wr(AUX, 8'hFF);
        rd(AUX, v); chk("R2 aux readback", v, 8'h03);
        chk("R2 crc_en set", crc_en, 1);
        chk("R3 buf_mode on", buf_mode, 1);
        wr(AUX, 8'h02);
        rd(AUX, v); chk("R2 aux readback 2", v, 8'h02);
        chk("R2 crc_en clear", crc_en, 0);

        // R11 count register
        wr(CNT, 8'h17);
        rd(CNT, v); chk("R11 count rw", v, 8'h17);

        // R5 host control read rewinds, write does not
        wr(HCTL, 8'h5C);
        rd(HCTL, v); chk("R5 hctl rw", v, 8'h5C);
        wr(BDAT, 8'h11); wr(BDAT, 8'h22);
        wr(HCTL, 8'h00);
        wr(BDAT, 8'h33);
        rd(HCTL, v);
        rd(BDAT, v); chk("R5 byte0", v, 8'h11);
        rd(BDAT, v); chk("R5 byte1", v, 8'h22);
        rd(BDAT, v); chk("R5 write to hctl kept index", v, 8'h33);

        // R3 raw I2C transfer: engine access ignored
        xfer_i2c_raw = 1'b1;
        #1 chk("R3 buf_mode off raw", buf_mode, 0);
        estart();
        epush(8'hEE, 1'b0);
        epop(v, 1'b0);
        xfer_i2c_raw = 1'b0;
        epop(v, 1'b1); chk("R3 pop ignored, engine index 0", v, 8'h11);
        rd(HCTL, v);
        rd(BDAT, v); chk("R3 push ignored", v, 8'h11);

        // R10 invalid counts
        estart();
        ecnt(8'd0);
        chk("R10 count 0 err", dev_err, 1);
        rd(CNT, v); chk("R9 count 0 captured", v, 8'd0);
        epush(8'h99, 1'b1);
        rd(HCTL, v);
        rd(BDAT, v); chk("R10 push blocked", v, 8'h11);
        estart();
        chk("R10 start clears", dev_err, 0);
        ecnt(8'd33);
        chk("R10 count 33 err", dev_err, 1);
        estart();
        ecnt(8'd32);
        chk("R9 count 32 ok", dev_err, 0);
        ecnt(8'd1);
        chk("R9 count 1 ok", dev_err, 0);

        // R6 directed overrun
        rd(HCTL, v);
        for (int k = 0; k < 34; k++) wr(BDAT, 8'(k + 8'h40));
        rd(HCTL, v);
        for (int k = 0; k < 34; k++) begin
            rd(BDAT, v);
            chk("R6 directed overrun", v, exp_at(k));
        end

        // random mix
        for (int it = 0; it < 24; it++) begin
            int n, c, p;
            n = 1 + ($urandom % 40);
            rd(HCTL, v);
            for (int k = 0; k < n; k++) wr(BDAT, 8'($urandom));
            rd(HCTL, v);
            for (int k = 0; k < n; k++) begin
                rd(BDAT, v);
                chk("R4 R6 software readback", v, exp_at(k));
            end
            estart();
            for (int k = 0; k < n; k++) begin
                epop(v, 1'b1);
                chk("R7 engine pop order", v, exp_at(k));
            end
            c = $urandom % 41;
            p = $urandom % 36;
            estart();
            ecnt(8'(c));
            chk("R10 random count flag", dev_err, (c == 0 || c > 32) ? 1 : 0);
            for (int k = 0; k < p; k++) epush(8'($urandom), 1'b1);
            rd(CNT, v); chk("R9 random count", v, 8'(c));
            rd(HCTL, v);
            for (int k = 0; k < 33; k++) begin
                rd(BDAT, v);
                chk("R8 R10 received bytes", v, exp_at(k));
            end
        end

        done = 1'b1;
        finish_run();
    end
endmodule